// File: doc/BRIEF.md
# Bit-Test-and-Branch Sequencer

This unit carries out the two conditional branch instructions of an 8-bit CPU that test one bit of a byte in the lowest 256 bytes of memory. One form branches when the bit is one. The other form branches when the bit is zero. The CPU core fetches the opcode, raises `start` for one cycle and presents the low opcode bits together with the address of the byte that follows the opcode.

The unit then reads two bytes over a byte-wide synchronous read port: first the direct-page operand address, then a signed displacement. It reads the operand byte and picks out the bit that the opcode selects. It reports the next program counter and the new carry value in a single-cycle `done` strobe.

Read data on the memory port is valid in the cycle after the cycle in which the strobe was raised. The next sequential instruction starts two bytes after `pc_in`.

Top module: `bitbr_unit`

## Requirements
- R1: A synchronous reset returns the unit to idle. In the cycle after a reset edge, `mem_rd` and `done` are both low. This holds even when the reset arrives in the middle of an instruction.
- R2: `start` is taken only while the unit is idle. A `start` seen during the read cycles, the evaluate cycle or the `done` cycle has no effect: no extra reads happen and no extra `done` strobe appears. The unit is idle again in the cycle after `done`.
- R3: After an accepted `start`, `mem_rd` is high for three consecutive cycles. The addresses are `pc_in`, then `pc_in`+1 (modulo 2^16), then the byte just read zero-extended to 16 bits. `mem_rd` is low at all other times.
- R4: `opcode[3:1]` is the bit number n (0 to 7) and `opcode[0]` is the polarity. Polarity 0 branches when bit n is 1. Polarity 1 branches when bit n is 0.
- R5: On every instruction, taken or not, `carry_out` equals the tested bit while `done` is high.
- R6: When the condition holds, `pc_next` = `pc_in` + 2 + the sign-extended displacement, modulo 2^16. This gives a reach of -128 to +127 bytes from the next instruction.
- R7: When the condition fails, `pc_next` = `pc_in` + 2, modulo 2^16.
- R8: `done` is high for exactly one cycle, five cycles after the edge that accepts `start`. The cycle between the last read and `done` has no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 4 | Low opcode bits: bit number in [3:1], polarity in [0] |
| pc_in | input | 16 | Address of the byte following the opcode |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle completion strobe |
| pc_next | output | 16 | Next program counter, valid with `done` |
| carry_out | output | 1 | New carry flag value, valid with `done` |

## Verification
Completion of one instruction and the request for the next can fall in the same cycle: `done` is high while `start` is already asserted. This is provoked by holding `start` high across a whole instruction, and by raising it again right on the `done` cycle. The reference model accepts a request only when it has no pending work. The request in the `done` cycle must therefore be ignored, and the next one must be taken a cycle later. Every clock, the bench compares the read strobe, the read address, `done`, the next PC and the carry against the model.

// File: rtl/bitbr_unit.sv
module bitbr_unit #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [$clog2(DW):0]     opcode,
  input  logic [AW-1:0]           pc_in,
  output logic [AW-1:0]           mem_addr,
  output logic                    mem_rd,
  input  logic [DW-1:0]           mem_rdata,
  output logic                    done,
  output logic [AW-1:0]           pc_next,
  output logic                    carry_out
);
  localparam int BW = $clog2(DW);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADR = 3'd1, S_OFF = 3'd2,
                         S_OPR = 3'd3, S_EVL = 3'd4, S_DON = 3'd5;

  logic [2:0]    state;
  logic [BW:0]   op_q;
  logic [AW-1:0] pc_q, seq_pc, rel;
  logic [DW-1:0] dir_q, off_q;
  logic          tbit, taken;

  assign seq_pc = pc_q + AW'(2);
  assign rel    = {{(AW-DW){off_q[DW-1]}}, off_q};
  assign tbit   = mem_rdata[op_q[BW:1]];
  assign taken  = tbit ^ op_q[0];
  assign mem_rd = (state == S_ADR) || (state == S_OFF) || (state == S_OPR);
  assign done   = (state == S_DON);

  always_comb begin
    case (state)
      S_ADR:   mem_addr = pc_q;
      S_OFF:   mem_addr = pc_q + AW'(1);
      S_OPR:   mem_addr = AW'(dir_q);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pc_next   <= '0;
      carry_out <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_q  <= opcode;
          pc_q  <= pc_in;
          state <= S_ADR;
        end
        S_ADR: state <= S_OFF;
        S_OFF: begin
          dir_q <= mem_rdata;
          state <= S_OPR;
        end
        S_OPR: begin
          off_q <= mem_rdata;
          state <= S_EVL;
        end
        S_EVL: begin
          carry_out <= tbit;
          pc_next   <= taken ? seq_pc + rel : seq_pc;
          state     <= S_DON;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitbr_unit_chk.sv
module bitbr_unit_chk #(
  parameter int AW = 16,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] pc_next,
  input logic          carry_out,
  input logic [2:0]    state,
  input logic [BW:0]   op_q,
  input logic [AW-1:0] pc_q
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!mem_rd && !done));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R3
  no_read_at_done_chk: assert property (@(posedge clk) disable iff (rst) done |-> !mem_rd);
  // R3
  second_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd) && !$past(mem_rd, 2) && !$past(rst)) |-> (mem_addr == AW'(pc_q + AW'(1))));
  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && state != 3'd0) |=> $stable(pc_q));
  // R7
  not_taken_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (carry_out == op_q[0])) |-> (pc_next == AW'(pc_q + AW'(2))));
endmodule

bind bitbr_unit bitbr_unit_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .pc_next(pc_next), .carry_out(carry_out),
  .state(state), .op_q(op_q), .pc_q(pc_q)
);

// File: tb/test_bitbr_unit.sv
module test_bitbr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, start = 0;
  logic [3:0]  opcode = 0;
  logic [15:0] pc_in = 0;
  logic [15:0] mem_addr, pc_next;
  logic        mem_rd, done, carry_out;
  logic [7:0]  mem_rdata = 0;

  int n_cmp = 0, n_bad = 0;
  bit ended = 0, clocked = 0;
  string phase = "R1";

  typedef struct {
    logic        rd;
    logic [15:0] addr;
    logic        dn;
    logic [15:0] pc;
    logic        c;
    string       tag;
  } ent_t;
  ent_t q[$];
  logic [7:0] mem [int];

  bitbr_unit i_bitbr_unit (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .pc_in(pc_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .done(done), .pc_next(pc_next), .carry_out(carry_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rdm(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= rdm(mem_addr);

  always @(posedge clk) begin
    clocked <= 1;
    if (rst) q.delete();
    else if (q.size() > 0) void'(q.pop_front());
    else if (start) begin
      logic [7:0] d, o, v;
      logic [15:0] nxt;
      logic b, tk;
      ent_t e;
      d = rdm(pc_in); o = rdm(pc_in + 16'd1); v = rdm({8'h00, d});
      b = v[opcode[3:1]]; tk = b ^ opcode[0];
      nxt = pc_in + 16'd2;
      e = '{1'b1, pc_in, 1'b0, 16'h0, 1'b0, "R3"}; q.push_back(e);
      e.addr = pc_in + 16'd1; q.push_back(e);
      e.addr = {8'h00, d}; q.push_back(e);
      e = '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, "R8"}; q.push_back(e);
      e = '{1'b0, 16'h0, 1'b1, tk ? nxt + {{8{o[7]}}, o} : nxt, b, tk ? "R6" : "R7"};
      q.push_back(e);
    end
  end

  task automatic cmp1(input string t, input string f, input logic [15:0] a, input logic [15:0] x);
    n_cmp++;
    if (a !== x) begin
      n_bad++;
      $display("FAIL %s (%s) %s: actual %h expected %h at %0t", t, phase, f, a, x, $time);
    end
  endtask

  always @(negedge clk) if (clocked && !ended) begin
    ent_t e;
    if (q.size() > 0) e = q[0];
    else e = '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, "R2"};
    cmp1(e.rd ? "R3" : (q.size() == 0 ? "R2" : "R8"), "mem_rd", 16'(mem_rd), 16'(e.rd));
    if (e.rd) cmp1("R3", "mem_addr", mem_addr, e.addr);
    cmp1(e.dn ? e.tag : "R8", "done", 16'(done), 16'(e.dn));
    if (e.dn) begin
      cmp1(e.tag, "pc_next", pc_next, e.pc);
      cmp1("R5", "carry_out", 16'(carry_out), 16'(e.c));
    end
  end

  task automatic run(input string ph, input logic [3:0] op, input logic [15:0] pc,
                     input logic [7:0] dir, input logic [7:0] off, input logic [7:0] val);
    phase = ph;
    mem.delete();
    mem[int'(pc)] = dir;
    mem[int'(16'(pc + 16'd1))] = off;
    mem[int'({8'h00, dir})] = val;
    @(negedge clk); opcode = op; pc_in = pc; start = 1;
    @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary;
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    phase = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    run("R4", 4'h0, 16'h0200, 8'h10, 8'h05, 8'h01);
    run("R4", 4'hF, 16'h0300, 8'h20, 8'h80, 8'h7F);
    run("R7", 4'h6, 16'h0400, 8'h30, 8'h10, 8'hF7);
    run("R6", 4'h9, 16'h0500, 8'h31, 8'h7F, 8'hEF);
    run("R6", 4'hE, 16'hFFF0, 8'h40, 8'h7F, 8'h80);
    run("R3", 4'h2, 16'hFFFF, 8'h41, 8'h02, 8'h02);
    for (int k = 0; k < 16; k++) run("R4", 4'(k), 16'h1000 + 16'(k * 3), 8'h50, 8'hF0, 8'hA5);
    phase = "R2";
    mem.delete();
    mem[32'h0600] = 8'h60; mem[32'h0601] = 8'h04; mem[32'h0060] = 8'h08;
    @(negedge clk); opcode = 4'h6; pc_in = 16'h0600; start = 1;
    repeat (11) @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    phase = "R2";
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    start = 1;
    @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    phase = "R1";
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    repeat (6) @(negedge clk);
    summary();
  end
endmodule